// File: doc/BRIEF.md
# Parallel LCD Bus Master Sequencer

This block is the master side of an 8-bit parallel bus used by LCD controllers. The bus has an active-low chip select, a register-select line, a read/write line and an enable strobe, plus a data bus that can be driven in both directions. The host starts one transaction with one request. The request carries a command byte, a direction, a beat count from 1 to 32, a dummy-read option and a half-period for the strobe.

Each transaction has a fixed frame. The block lowers chip select and sends the command byte in one write beat with register-select low. It then raises register-select, sets read/write for the requested direction and runs the data beats. Write bytes are pulled from the host one per beat. Read bytes are returned with a one-cycle valid pulse. When the data beats are finished, the block waits one half period, releases chip select and pulses done. The output enable for the data bus is a separate port; the pad itself sits outside the block.

Top module: `lcd_bus_seq`

## Requirements
- R1: After reset and between transactions the bus is idle: lcd_cs_n=1, lcd_rs=1, lcd_rw=1, lcd_en=0, lcd_doe=0 and busy=0.
- R2: Every transaction opens with exactly one command beat. During that beat lcd_cs_n=0, lcd_rs=0, lcd_rw=0, lcd_doe=1 and lcd_dout equals req_cmd. Chip select falls at least one half period before the strobe rises.
- R3: During the data phase lcd_rs=1 and lcd_rw equals the direction (0 write, 1 read) on every cycle. lcd_rs and lcd_rw change only while lcd_en is low.
- R4: The strobe is high for exactly H+1 clock cycles on each beat. It is low for at least H+1 cycles before each rising edge. H is the value of half_div latched when the request is taken.
- R5: A write carries req_beats_m1+1 data beats (field value v gives v+1 beats, v from 0 to 31). On each beat lcd_dout is updated at the strobe's rising edge to the current wr_data byte, and wr_take pulses for one cycle in that same cycle.
- R6: During the whole read data phase lcd_doe is 0. lcd_din is sampled on the falling edge of the strobe, and each kept byte appears on rd_data with a one-cycle rd_valid pulse.
- R7: On a read with req_dummy=1, one extra beat runs before the real beats, and its data is discarded (no rd_valid). On a write, req_dummy has no effect.
- R8: Chip select stays low for at least H+1 cycles after the last strobe falling edge. It then returns high in the same cycle as a one-cycle done pulse and busy dropping to 0.
- R9: A request raised while busy is ignored. It starts no further transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, taken only when idle |
| req_cmd | input | 8 | Command byte |
| req_read | input | 1 | 1 = read data phase, 0 = write |
| req_beats_m1 | input | 5 | Data beat count minus one |
| req_dummy | input | 1 | Insert a discarded read beat (reads only) |
| half_div | input | 8 | Strobe half period minus one, in clock cycles |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse at the end of a transaction |
| wr_data | input | 8 | Current write byte offered by the host |
| wr_take | output | 1 | wr_data was consumed; host presents the next byte |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data is new this cycle |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select: 0 command, 1 data |
| lcd_rw | output | 1 | 0 write, 1 read |
| lcd_en | output | 1 | Enable strobe / beat clock |
| lcd_dout | output | 8 | Data bus output value |
| lcd_doe | output | 1 | Data bus output enable |
| lcd_din | input | 8 | Data bus input value |

## Verification
The assertions check the following on every cycle: the idle levels, the strobe confined inside chip select, register-select and read/write moving only while the strobe is low, the data bus released on reads, and wr_take and rd_valid lining up with strobe edges. Some properties span a whole transaction, and only the bench's scenarios can show them. These are the exact beat count including the dummy beat, the byte order on both directions, the strobe widths against the latched half period, the hold of chip select after the last beat, and the rejection of a request made while busy.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_CMD_HI,
    S_TURN,
    S_GAP,
    S_DHI,
    S_TAIL
  } seq_state_t;
endpackage

// File: rtl/lcd_half_tick.sv
module lcd_half_tick #(
  parameter int HDW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic [HDW-1:0] reload,
  output logic           tick
);
  logic [HDW-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= reload;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4: the half-period counter never exceeds the latched reload value
  a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= reload));
endmodule

// File: rtl/lcd_beat_ctr.sv
module lcd_beat_ctr #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] limit,
  input  logic          step,
  output logic [CW-1:0] idx,
  output logic          last
);
  logic [CW-1:0] idx_q;
  logic [CW-1:0] limit_q;

  assign idx  = idx_q;
  assign last = (idx_q == limit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      limit_q <= '0;
    end else if (load) begin
      idx_q   <= '0;
      limit_q <= limit;
    end else if (step && !last) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // R5: the beat index stays inside the requested beat range
  a_r5_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    idx_q <= limit_q);
endmodule

// File: rtl/lcd_bus_seq.sv
module lcd_bus_seq
  import lcd_seq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_BEATS = 32,
  parameter int HDW       = 8,
  localparam int BW       = $clog2(MAX_BEATS),
  localparam int CW       = $clog2(MAX_BEATS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic [DW-1:0]  req_cmd,
  input  logic           req_read,
  input  logic [BW-1:0]  req_beats_m1,
  input  logic           req_dummy,
  input  logic [HDW-1:0] half_div,
  output logic           busy,
  output logic           done,
  input  logic [DW-1:0]  wr_data,
  output logic           wr_take,
  output logic [DW-1:0]  rd_data,
  output logic           rd_valid,
  output logic           lcd_cs_n,
  output logic           lcd_rs,
  output logic           lcd_rw,
  output logic           lcd_en,
  output logic [DW-1:0]  lcd_dout,
  output logic           lcd_doe,
  input  logic [DW-1:0]  lcd_din
);
  seq_state_t     state_q;
  logic [HDW-1:0] hdiv_q;
  logic [DW-1:0]  cmd_q;
  logic           rd_q;
  logic           dummy_q;
  logic           start;
  logic           tick;
  logic [HDW-1:0] reload;
  logic [CW-1:0]  beat_limit;
  logic [CW-1:0]  beat_idx;
  logic           beat_last;
  logic           beat_step;
  logic           keep_beat;

  assign start      = (state_q == S_IDLE) && req_valid;
  assign busy       = (state_q != S_IDLE);
  assign reload     = (state_q == S_IDLE) ? half_div : hdiv_q;
  assign beat_limit = CW'(req_beats_m1) + CW'(req_read & req_dummy);
  assign beat_step  = (state_q == S_DHI) && tick;
  assign keep_beat  = !(dummy_q && (beat_idx == '0));

  lcd_half_tick #(.HDW(HDW)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run    (busy),
    .reload (reload),
    .tick   (tick)
  );

  lcd_beat_ctr #(.CW(CW)) u_beats (
    .clk   (clk),
    .rst   (rst),
    .load  (start),
    .limit (beat_limit),
    .step  (beat_step),
    .idx   (beat_idx),
    .last  (beat_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      hdiv_q   <= '0;
      cmd_q    <= '0;
      rd_q     <= 1'b0;
      dummy_q  <= 1'b0;
      lcd_cs_n <= 1'b1;
      lcd_rs   <= 1'b1;
      lcd_rw   <= 1'b1;
      lcd_en   <= 1'b0;
      lcd_dout <= '0;
      lcd_doe  <= 1'b0;
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
    end else begin
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            hdiv_q   <= half_div;
            cmd_q    <= req_cmd;
            rd_q     <= req_read;
            dummy_q  <= req_read & req_dummy;
            lcd_cs_n <= 1'b0;
            lcd_rs   <= 1'b0;
            lcd_rw   <= 1'b0;
            lcd_doe  <= 1'b1;
            state_q  <= S_SETUP;
          end
        end
        S_SETUP: begin
          if (tick) begin
            lcd_en   <= 1'b1;
            lcd_dout <= cmd_q;
            state_q  <= S_CMD_HI;
          end
        end
        S_CMD_HI: begin
          if (tick) begin
            lcd_en  <= 1'b0;
            state_q <= S_TURN;
          end
        end
        S_TURN: begin
          if (tick) begin
            lcd_rs  <= 1'b1;
            lcd_rw  <= rd_q;
            lcd_doe <= !rd_q;
            state_q <= S_GAP;
          end
        end
        S_GAP: begin
          if (tick) begin
            lcd_en <= 1'b1;
            if (!rd_q) begin
              lcd_dout <= wr_data;
              wr_take  <= 1'b1;
            end
            state_q <= S_DHI;
          end
        end
        S_DHI: begin
          if (tick) begin
            lcd_en <= 1'b0;
            if (rd_q && keep_beat) begin
              rd_data  <= lcd_din;
              rd_valid <= 1'b1;
            end
            state_q <= beat_last ? S_TAIL : S_GAP;
          end
        end
        S_TAIL: begin
          if (tick) begin
            lcd_cs_n <= 1'b1;
            lcd_rs   <= 1'b1;
            lcd_rw   <= 1'b1;
            lcd_doe  <= 1'b0;
            done     <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R1: idle bus levels whenever no transaction runs
  a_r1_idle_levels: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (lcd_cs_n && lcd_rs && lcd_rw && !lcd_en));
  // R2: the strobe only pulses inside chip select
  a_r2_en_in_cs: assert property (@(posedge clk) disable iff (rst)
    lcd_en |-> !lcd_cs_n);
  // R3: register select moves only while the strobe is low
  a_r3_rs_moves_en_low: assert property (@(posedge clk) disable iff (rst)
    (lcd_rs != $past(lcd_rs)) |-> !lcd_en);
  // R3: read/write is steady through the data phase
  a_r3_rw_steady: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && lcd_rs && $past(!lcd_cs_n && lcd_rs)) |-> $stable(lcd_rw));
  // R6: bus released while reading
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && lcd_rw) |-> !lcd_doe);
  // R5: write byte consumed at a strobe rising edge of a write
  a_r5_take_at_rise: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> (lcd_en && !$past(lcd_en) && !lcd_rw));
  // R6: read byte delivered at a strobe falling edge of a read
  a_r6_valid_at_fall: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (!lcd_en && $past(lcd_en) && lcd_rw));
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/test_lcd_bus_seq.sv
module test_lcd_bus_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [7:0] req_cmd = '0;
  logic       req_read = 1'b0;
  logic [4:0] req_beats_m1 = '0;
  logic       req_dummy = 1'b0;
  logic [7:0] half_div = '0;
  logic       busy, done, wr_take, rd_valid;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       lcd_cs_n, lcd_rs, lcd_rw, lcd_en, lcd_doe;
  logic [7:0] lcd_dout;
  logic [7:0] lcd_din = '0;

  int nchk = 0;
  int nfail = 0;
  int txn = 0;

  always #2.5 clk = ~clk;

  lcd_bus_seq i_lcd_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_read(req_read), .req_beats_m1(req_beats_m1), .req_dummy(req_dummy),
    .half_div(half_div), .busy(busy), .done(done), .wr_data(wr_data),
    .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
    .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
  );

  function automatic logic [7:0] wr_pat(input int t, input int k);
    return 8'((t * 37 + k * 13 + 5) & 255);
  endfunction

  function automatic logic [7:0] rd_pat(input int t, input int k);
    return 8'((t * 91 + k * 29 + 17) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s txn=%0d actual=%0d expected=%0d", req, txn, act, exp);
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  task automatic check_idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R1 idle cs_n", lcd_cs_n, 1);
      chk("R1 idle rs", lcd_rs, 1);
      chk("R1 idle rw", lcd_rw, 1);
      chk("R1 idle en", lcd_en, 0);
      chk("R1 idle doe", lcd_doe, 0);
      chk("R1 R9 idle busy", busy, 0);
    end
  endtask

  task automatic run_txn(input bit rd, input int nb, input bit dm, input int h,
                         input bit poke);
    logic [7:0] cmd;
    int pulses, hi_cnt, lo_cnt, wr_cnt, rd_cnt, exp_pulses;
    bit pen, pcs, fin;
    txn++;
    cmd = 8'($urandom);
    @(negedge clk);
    req_valid    = 1'b1;
    req_cmd      = cmd;
    req_read     = rd;
    req_beats_m1 = 5'(nb - 1);
    req_dummy    = dm;
    half_div     = 8'(h);
    wr_data      = wr_pat(txn, 0);
    @(negedge clk);
    req_valid = 1'b0;
    half_div  = 8'($urandom_range(0, 7));
    chk("R2 cs falls on request", lcd_cs_n, 0);
    pulses = 0; hi_cnt = 0; lo_cnt = 1; wr_cnt = 0; rd_cnt = 0;
    pen = 1'b0; pcs = 1'b0; fin = 1'b0;
    exp_pulses = 1 + nb + ((rd && dm) ? 1 : 0);
    for (int c = 0; c < 20000 && !fin; c++) begin
      @(negedge clk);
      if (poke && c == 3) begin
        req_valid = 1'b1; req_cmd = 8'hA5; req_read = !rd; req_beats_m1 = 5'd31;
      end
      if (poke && c == 4) req_valid = 1'b0;
      if (lcd_en && !pen) begin
        pulses++;
        chk("R4 low time before rise", (lo_cnt >= h + 1) ? 1 : 0, 1);
        chk("R2 cs low at strobe", lcd_cs_n, 0);
        if (pulses == 1) begin
          chk("R2 cmd rs", lcd_rs, 0);
          chk("R2 cmd rw", lcd_rw, 0);
          chk("R2 cmd doe", lcd_doe, 1);
          chk("R2 cmd byte", lcd_dout, cmd);
        end else begin
          chk("R3 data rs", lcd_rs, 1);
          chk("R3 data rw", lcd_rw, rd);
          if (!rd) begin
            chk("R5 write doe", lcd_doe, 1);
            chk("R5 write byte", lcd_dout, wr_pat(txn, pulses - 2));
          end else begin
            chk("R6 read doe", lcd_doe, 0);
            lcd_din = rd_pat(txn, pulses - 2);
          end
        end
        hi_cnt = 1;
      end else if (lcd_en) begin
        hi_cnt++;
      end else if (pen) begin
        chk("R4 strobe high width", hi_cnt, h + 1);
        lo_cnt = 1;
      end else begin
        lo_cnt++;
      end
      if (pulses >= 2 && !lcd_cs_n) begin
        chk("R3 rs in data phase", lcd_rs, 1);
        chk("R3 rw in data phase", lcd_rw, rd);
        if (rd) chk("R6 doe off in read phase", lcd_doe, 0);
      end
      if (wr_take) begin
        chk("R5 wr_take on write only", rd, 0);
        chk("R5 wr_take aligned to rise", (lcd_en && !pen) ? 1 : 0, 1);
        wr_cnt++;
        wr_data = wr_pat(txn, wr_cnt);
      end
      if (rd_valid) begin
        chk("R6 R7 read byte", rd_data, rd_pat(txn, rd_cnt + (dm ? 1 : 0)));
        rd_cnt++;
      end
      if (done) begin
        chk("R8 cs high with done", lcd_cs_n, 1);
        chk("R8 cs low just before done", pcs, 0);
        chk("R8 hold after last beat", (lo_cnt >= h + 2) ? 1 : 0, 1);
        chk("R8 busy low with done", busy, 0);
        chk("R5 R7 strobe pulse count", pulses, exp_pulses);
        if (rd) chk("R6 R7 read byte count", rd_cnt, nb);
        else    chk("R5 write byte count", wr_cnt, nb);
        fin = 1'b1;
      end
      pen = lcd_en;
      pcs = lcd_cs_n;
    end
    chk("R8 transaction finished", fin, 1);
    check_idle(poke ? 6 : 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired txn=%0d actual=1 expected=0", txn);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_idle(2);
    run_txn(1'b0, 1,  1'b0, 0, 1'b0);
    run_txn(1'b0, 32, 1'b0, 2, 1'b0);
    run_txn(1'b1, 1,  1'b1, 1, 1'b0);
    run_txn(1'b1, 32, 1'b1, 3, 1'b0);
    run_txn(1'b1, 4,  1'b0, 0, 1'b0);
    run_txn(1'b0, 3,  1'b1, 1, 1'b0);
    run_txn(1'b0, 5,  1'b0, 2, 1'b1);
    run_txn(1'b1, 2,  1'b1, 1, 1'b1);
    for (int i = 0; i < 24; i++) begin
      run_txn(1'($urandom), int'($urandom_range(1, 32)), 1'($urandom),
              int'($urandom_range(0, 5)), 1'($urandom_range(0, 3) == 0));
    end
    summary();
    $finish;
  end
endmodule